// File: doc/BRIEF.md
# Binary-Weight Strided Convolution Grid

This block is a square grid of identical processing cells (8×8 by default) that holds one image tile of signed pixels and one sign bit per cell. The sign bits carry a 4×4 kernel whose entries are each +1 or -1, repeated over the whole grid. Every cell executes the same operation in the same clock. A convolution is built without any multiplier. First each cell keeps or negates its pixel according to its sign bit. Then a fixed chain of shift-and-add steps folds every aligned 4×4 block of cells into that block's lower-right cell.

One such pass gives one result per 4×4 block, which is a stride of 4. For a stride of 2 or 1 the pass is repeated 4 or 16 times. On each repeat the kernel sits at a different offset inside the block, and each pass drops its block results into an output buffer. Pixels and sign bits enter through a valid/ready load stream. Convolution results leave through a valid/ready readout stream that honours back-pressure: a result stays on `out_data` until `out_ready` takes it, and nothing is skipped or repeated. The start command, stride code, busy flag and done pulse are plain level signals.

Top module: `bwc_conv_array`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done` and `out_valid` are 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the block is idle. Each beat with `in_valid` and `in_ready` both high writes `in_pixel` and `in_weight` into the next cell in row-major order, and the order wraps after GRID×GRID beats. A beat offered while busy is not taken and leaves later results unchanged.
- R3: A weight bit of 1 means +1, and the pixel is kept. A weight bit of 0 means -1, and the pixel is negated. No bias is added to any result.
- R4: With stride 4, the block produces (GRID/4)×(GRID/4) results. Each result is the signed sum of the 16 sign-applied pixels of one aligned 4×4 block.
- R5: The stride codes on `stride_sel` are: 0 selects stride 1, 1 selects stride 2, and 2 or 3 select stride 4. The run takes (4/s)² passes of 8 cycles each. `done` is high in the cycle that follows the 8·(4/s)²-th clock edge after the edge that accepted `start`.
- R6: With stride s, the result at output row i and column j equals the sum over a, b in 0..3 of sign(weight[a][b]) × pixel[s·i+a][s·j+b]. Pixels that fall outside the grid count as 0.
- R7: The readout sends (GRID/s)×(GRID/s) results in row-major order. `out_last` is high on the final result only.
- R8: `done` is high for exactly one cycle per run, and the first result is offered in that same cycle. `busy` is high from the edge that accepts `start` until the edge that takes the final result.
- R9: A `start` that arrives while `busy` is high has no effect. The stride, the timing and the results of the current run are unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load beat offered |
| in_ready | output | 1 | Load beat can be taken (idle) |
| in_pixel | input | DW | Signed pixel for the next cell |
| in_weight | input | 1 | Sign bit for the next cell: 1 is +1, 0 is -1 |
| start | input | 1 | Begin a convolution run (taken only when idle) |
| stride_sel | input | 2 | Stride code: 0 is stride 1, 1 is stride 2, 2 and 3 are stride 4 |
| busy | output | 1 | Run or readout in progress |
| done | output | 1 | One-cycle pulse after the last pass |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the offered result |
| out_data | output | DW | Signed convolution result |
| out_last | output | 1 | Final result of the run |

## Verification
Each pass costs a fixed 8 clocks: one sign step, six fold steps and one store. The bench therefore counts falling edges from the edge that accepted `start` and requires `done` exactly at 8, 32 or 128 counts for strides 4, 2 and 1. It also requires `done` to be low one count later. A loaded beat lands one edge after it is offered, so the tile is complete before `start` is raised. Readout results are due from the `done` cycle onward. The bench drives `out_ready` at each falling edge and samples one time step later, so a result is counted only when that edge's handshake will take it. It compares the held value across the stalled cycles. After the final handshake edge it expects `busy` low.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  // Per-cell operation broadcast to the whole grid; order matters: the
  // sequencer maps its step counter 0..6 onto OP_MUL..OP_KROW.
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_MUL  = 3'd1,  // sign-apply the (offset) pixel
    OP_W1   = 3'd2,  // add value from one column to the west
    OP_W2   = 3'd3,  // add value from two columns to the west
    OP_N1   = 3'd4,  // add value from one row to the north
    OP_N2   = 3'd5,  // add value from two rows to the north
    OP_KCOL = 3'd6,  // clear cells not in the last column of a block
    OP_KROW = 3'd7   // clear cells not in the last row of a block
  } cell_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STORE = 2'd2,
    ST_SEND  = 2'd3
  } seq_state_e;

  localparam int KDIM = 4;

  // log2 of the stride for a stride code
  function automatic logic [1:0] stride_log2(input logic [1:0] code);
    return (code > 2'd1) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/bwc_tile_store.sv
module bwc_tile_store #(
  parameter int GRID = 8,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] wr_pix,
  input  logic                 wr_wgt,
  output logic signed [DW-1:0] pix [GRID][GRID],
  output logic                 wgt [GRID][GRID]
);
  localparam int NCELL = GRID * GRID;
  localparam int AW    = $clog2(NCELL);

  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (wr_en) ptr <= (ptr == AW'(NCELL - 1)) ? '0 : ptr + 1'b1;
  end

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pix[r][c] <= '0;
          wgt[r][c] <= 1'b1;
        end else if (wr_en && ptr == AW'(r * GRID + c)) begin
          pix[r][c] <= wr_pix;
          wgt[r][c] <= wr_wgt;
        end
      end
    end
  end

endmodule

// File: rtl/bwc_cell_grid.sv
module bwc_cell_grid
  import bwc_pkg::*;
#(
  parameter int GRID = 8,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cell_op_e             op,
  input  logic [1:0]           off_r,
  input  logic [1:0]           off_c,
  input  logic signed [DW-1:0] pix [GRID][GRID],
  input  logic                 wgt [GRID][GRID],
  output logic signed [DW-1:0] v   [GRID][GRID]
);
  localparam int IW = $clog2(GRID);

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      localparam bit LAST_COL = (c % KDIM) == KDIM - 1;
      localparam bit LAST_ROW = (r % KDIM) == KDIM - 1;

      logic signed [DW-1:0] w1, w2, n1, n2, src;
      logic [IW:0] sr, sc;

      // neighbour taps, zero beyond the grid edge
      if (c >= 1) begin : g_w1 assign w1 = v[r][c-1]; end
      else        begin : g_w1z assign w1 = '0; end
      if (c >= 2) begin : g_w2 assign w2 = v[r][c-2]; end
      else        begin : g_w2z assign w2 = '0; end
      if (r >= 1) begin : g_n1 assign n1 = v[r-1][c]; end
      else        begin : g_n1z assign n1 = '0; end
      if (r >= 2) begin : g_n2 assign n2 = v[r-2][c]; end
      else        begin : g_n2z assign n2 = '0; end

      // pixel at the kernel offset; top bit set means outside the grid
      always_comb begin
        sr = (IW+1)'(r) + (IW+1)'(off_r);
        sc = (IW+1)'(c) + (IW+1)'(off_c);
        if (sr[IW] || sc[IW]) src = '0;
        else                  src = pix[sr[IW-1:0]][sc[IW-1:0]];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v[r][c] <= '0;
        else begin
          case (op)
            OP_MUL:  v[r][c] <= wgt[r][c] ? src : -src;
            OP_W1:   v[r][c] <= v[r][c] + w1;
            OP_W2:   v[r][c] <= v[r][c] + w2;
            OP_N1:   v[r][c] <= v[r][c] + n1;
            OP_N2:   v[r][c] <= v[r][c] + n2;
            OP_KCOL: if (!LAST_COL) v[r][c] <= '0;
            OP_KROW: if (!LAST_ROW) v[r][c] <= '0;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/bwc_sequencer.sv
module bwc_sequencer
  import bwc_pkg::*;
#(
  parameter int GRID = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              stride_sel,
  output cell_op_e                op,
  output logic [1:0]              off_r,
  output logic [1:0]              off_c,
  output logic                    store_en,
  output logic [1:0]              lg,
  output logic [1:0]              pr,
  output logic [1:0]              pc,
  output logic                    busy,
  output logic                    done,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_last,
  output logic [$clog2(GRID)-1:0] rd_row,
  output logic [$clog2(GRID)-1:0] rd_col
);
  localparam int IW   = $clog2(GRID);
  localparam int NSTP = 6;

  seq_state_e state;
  logic [2:0] step;
  logic [1:0] pmax;
  logic [IW-1:0] nmax;

  assign pmax      = 2'(2'd3 >> lg);
  assign nmax      = IW'((GRID >> lg) - 1);
  assign off_r     = 2'(pr << lg);
  assign off_c     = 2'(pc << lg);
  assign store_en  = (state == ST_STORE);
  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_SEND);
  assign out_last  = (rd_row == nmax) && (rd_col == nmax);
  assign op        = (state == ST_RUN) ? cell_op_e'(step + 3'd1) : OP_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      lg     <= 2'd2;
      pr     <= '0;
      pc     <= '0;
      done   <= 1'b0;
      rd_row <= '0;
      rd_col <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          lg    <= stride_log2(stride_sel);
          pr    <= '0;
          pc    <= '0;
          step  <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (step == 3'(NSTP)) state <= ST_STORE;
          else                  step  <= step + 1'b1;
        end
        ST_STORE: begin
          step <= '0;
          if (pr == pmax && pc == pmax) begin
            done   <= 1'b1;
            rd_row <= '0;
            rd_col <= '0;
            state  <= ST_SEND;
          end else begin
            if (pc == pmax) begin
              pc <= '0;
              pr <= pr + 1'b1;
            end else begin
              pc <= pc + 1'b1;
            end
            state <= ST_RUN;
          end
        end
        ST_SEND: if (out_ready) begin
          if (rd_col == nmax) begin
            rd_col <= '0;
            if (rd_row == nmax) state <= ST_IDLE;
            else                rd_row <= rd_row + 1'b1;
          end else begin
            rd_col <= rd_col + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bwc_result_buf.sv
module bwc_result_buf
  import bwc_pkg::*;
#(
  parameter int GRID = 8,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    store_en,
  input  logic [1:0]              lg,
  input  logic [1:0]              pr,
  input  logic [1:0]              pc,
  input  logic signed [DW-1:0]    v [GRID][GRID],
  input  logic [$clog2(GRID)-1:0] rd_row,
  input  logic [$clog2(GRID)-1:0] rd_col,
  output logic signed [DW-1:0]    out_data
);
  localparam int IW = $clog2(GRID);
  localparam int NB = GRID / KDIM;

  logic signed [DW-1:0] obuf [GRID][GRID];

  // block (by,bx) at pass (pr,pc) lands at row by*(4/s)+pr, col bx*(4/s)+pc
  always_ff @(posedge clk) begin
    if (store_en) begin
      for (int by = 0; by < NB; by++) begin
        for (int bx = 0; bx < NB; bx++) begin
          obuf[IW'((by << (2 - int'(lg))) + int'(pr))]
              [IW'((bx << (2 - int'(lg))) + int'(pc))]
            <= v[KDIM*by + KDIM-1][KDIM*bx + KDIM-1];
        end
      end
    end
  end

  assign out_data = obuf[rd_row][rd_col];

endmodule

// File: rtl/bwc_conv_array.sv
module bwc_conv_array
  import bwc_pkg::*;
#(
  parameter int GRID = 8,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_pixel,
  input  logic          in_weight,
  input  logic          start,
  input  logic [1:0]    stride_sel,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int IW = $clog2(GRID);

  logic signed [DW-1:0] pix_w [GRID][GRID];
  logic                 wgt_w [GRID][GRID];
  logic signed [DW-1:0] val_w [GRID][GRID];
  logic signed [DW-1:0] res_w;
  cell_op_e             op_w;
  logic [1:0]           off_r_w, off_c_w, lg_w, pr_w, pc_w;
  logic                 store_w;
  logic [IW-1:0]        rd_row_w, rd_col_w;

  assign in_ready = !busy;
  assign out_data = res_w;

  bwc_tile_store #(.GRID(GRID), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid && in_ready),
    .wr_pix(in_pixel), .wr_wgt(in_weight), .pix(pix_w), .wgt(wgt_w)
  );

  bwc_sequencer #(.GRID(GRID)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stride_sel(stride_sel),
    .op(op_w), .off_r(off_r_w), .off_c(off_c_w), .store_en(store_w),
    .lg(lg_w), .pr(pr_w), .pc(pc_w), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .rd_row(rd_row_w), .rd_col(rd_col_w)
  );

  bwc_cell_grid #(.GRID(GRID), .DW(DW)) u_grid (
    .clk(clk), .rst_n(rst_n), .op(op_w), .off_r(off_r_w), .off_c(off_c_w),
    .pix(pix_w), .wgt(wgt_w), .v(val_w)
  );

  bwc_result_buf #(.GRID(GRID), .DW(DW)) u_rbuf (
    .clk(clk), .store_en(store_w), .lg(lg_w), .pr(pr_w), .pc(pc_w),
    .v(val_w), .rd_row(rd_row_w), .rd_col(rd_col_w), .out_data(res_w)
  );

endmodule

// File: rtl/bwc_conv_checker.sv
module bwc_conv_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_pixel,
  input logic          in_weight,
  input logic          start,
  input logic [1:0]    stride_sel,
  input logic          busy,
  input logic          done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last
);
  logic [15:0] lat, lat_exp;

  // cycle count since the accepting edge, and the expected run length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat     <= '0;
      lat_exp <= 16'd8;
    end else if (start && !busy) begin
      lat     <= '0;
      lat_exp <= (stride_sel == 2'd0) ? 16'd128 :
                 (stride_sel == 2'd1) ? 16'd32 : 16'd8;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !out_valid && in_ready));

  assert_no_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == lat_exp));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && out_valid));

  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind bwc_conv_array bwc_conv_checker #(.DW(DW)) u_chk (.*);

// File: tb/test_bwc_conv_array.sv
`timescale 1ns/1ps
module test_bwc_conv_array;
  localparam int GRID = 8;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_pixel = '0;
  logic          in_weight = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    stride_sel = 2'd2;
  logic          busy, done, out_valid, out_last;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int img [GRID][GRID];
  bit kw [4][4];

  always #5 clk = ~clk;

  bwc_conv_array #(.GRID(GRID), .DW(DW)) i_bwc_conv_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_weight(in_weight), .start(start),
    .stride_sel(stride_sel), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6 model: window at (s*i, s*j), zero outside the grid
  function automatic int model(input int lg, input int i, input int j);
    int s = 1 << lg;
    int sum = 0;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int r = s * i + a;
        int c = s * j + b;
        int p = (r < GRID && c < GRID) ? img[r][c] : 0;
        sum += kw[a][b] ? p : -p;
      end
    end
    return sum;
  endfunction

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic load_tile();
    for (int r = 0; r < GRID; r++) begin
      for (int c = 0; c < GRID; c++) begin
        @(negedge clk);
        in_valid  = 1'b1;
        in_pixel  = DW'(img[r][c]);
        in_weight = kw[r % 4][c % 4];
        if (r == 0 && c == 0) check("R2 in_ready idle", in_ready, 1);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_conv(input logic [1:0] code, input bit poke,
                          input bit bp, input string tag);
    int lg = (code > 2'd1) ? 2 : int'(code);
    int n = GRID >> lg;
    int passes = (4 >> lg) * (4 >> lg);
    int cnt = 0;
    int beats = 0;
    int guard = 0;
    bit held_v = 0;
    logic [DW-1:0] held;
    @(negedge clk);
    start = 1'b1;
    stride_sel = code;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, 1);
    while (!done && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      if (cnt == 2) begin
        check("R2 in_ready busy", in_ready, 0);
        in_valid = 1'b1;
        in_pixel = 16'h0155;
      end
      if (cnt == 3) begin
        in_valid = 1'b0;
        if (poke) begin
          start = 1'b1;
          stride_sel = 2'd0;
        end
      end
      if (cnt == 4) start = 1'b0;
    end
    check(poke ? "R9 latency unchanged" : "R5 done latency", cnt, 8 * passes);
    while (beats < n * n && guard < 5000) begin
      out_ready = bp ? ((guard % 3) != 1) : 1'b1;
      #1;
      if (guard == 1) check("R8 done one cycle", done, 0);
      if (held_v) check("R10 held data", int'(out_data), int'(held));
      if (!out_valid) check("R10 valid during readout", 0, 1);
      else if (out_ready) begin
        check({tag, " result"}, int'($signed(out_data)),
              int'($signed(DW'(model(lg, beats / n, beats % n)))));
        check("R7 out_last", out_last, (beats == n * n - 1) ? 1 : 0);
        beats++;
        held_v = 0;
      end else begin
        held = out_data;
        held_v = 1;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    check("R7 result count", beats, n * n);
    check("R8 idle after last", busy, 0);
    check("R8 no valid after last", out_valid, 0);
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < GRID; r++)
      for (int c = 0; c < GRID; c++)
        img[r][c] = ((r * 8 + c * 3) % 13) - 6;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        kw[a][b] = ((a * 5 + b * 3) % 4) < 2;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    load_tile();
    run_conv(2'd2, 0, 0, "R4 stride4 R3");
    run_conv(2'd1, 0, 1, "R6 stride2");
    run_conv(2'd0, 0, 1, "R6 stride1 edge");
    run_conv(2'd3, 1, 0, "R5 code3 R9");

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        kw[a][b] = 1'b1;
    load_tile();
    run_conv(2'd2, 0, 0, "R3 all plus");

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        kw[a][b] = 1'b0;
    for (int r = 0; r < GRID; r++)
      for (int c = 0; c < GRID; c++)
        img[r][c] = r - c + 2;
    load_tile();
    run_conv(2'd1, 0, 1, "R3 all minus");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule